// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after reset. It reads a configuration image from a three-wire serial EEPROM by driving the chip select, the serial clock and the data-in line directly, and by sampling the EEPROM's data-out line. It reads all 64 sixteen-bit words in ascending address order and keeps a 16-bit wrapping sum of them. When the whole image sums to the signature 0x1234, the block decodes three adapter settings from it: the host bus ID, the tag queue depth and an active-negation enable. When the sum does not match, all settings keep their defaults.

The `phase_div` input sets the length of each serial clock phase in core clock cycles, so the same block can meet the EEPROM's slow bit time from any core clock. When loading finishes, `done` pulses for one cycle. From that point `valid` reports the checksum result and the settings outputs stay fixed until the next reset. The serial pins then stay idle.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Each word read opens with 9 serial clock pulses carrying a start bit of 1, then the command byte 0x80 OR the word address, MSB first. `ee_di` is stable while `ee_sk` is high.
- R2: After the command, 16 more pulses clock in the data word MSB first. Each bit is sampled from `ee_do` at the end of the high phase of its pulse, which is after the rising edge. Each word frame therefore has exactly 25 rising edges.
- R3: Exactly 64 words are read, one per chip-select assertion, with addresses 0 to 63 in ascending order.
- R4: `ee_sk` is low whenever `ee_cs` is low. Chip select stays low for at least one phase before each word, including the first word after reset.
- R5: Every high phase of `ee_sk`, and every low phase of `ee_sk` while `ee_cs` is high, lasts exactly max(`phase_div`,1) clock cycles.
- R6: `valid` is 1 after loading exactly when the 16-bit wrapping sum of the 64 words equals 0x1234.
- R7: When the image is valid, `host_id` is bits 2:0 of byte 0x40 and `act_neg` is bit 3 of byte 0x41. Byte address b is the low byte of word b/2 when b is even and the high byte when b is odd. So `host_id` is word 32 bits 2:0 and `act_neg` is word 32 bit 11.
- R8: When the image is valid, `tag_depth` is 2 shifted left by byte 0x43 (word 33 bits 15:8), truncated to 16 bits. It is therefore 0 for byte values of 15 and above.
- R9: Under reset, during loading, and after a load whose image is invalid, `host_id` is 7, `act_neg` is 0 and `tag_depth` is 16.
- R10: `id_mask` is always one-hot, with its single set bit at position `host_id`.
- R11: `done` is high for exactly one cycle, after the last word's chip select falls. `valid` is 0 until then. From then on the outputs are stable, and `ee_cs` and `ee_sk` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset; loading starts when it is released |
| phase_div | input | 16 | Serial clock phase length in core clock cycles (0 acts as 1) |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| done | output | 1 | One-cycle pulse when loading completes |
| valid | output | 1 | Image checksum matched the signature |
| host_id | output | 3 | Host bus ID |
| id_mask | output | 8 | One-hot mask of the host ID |
| tag_depth | output | 16 | Tag queue depth |
| act_neg | output | 1 | Active-negation enable |

## Verification
A behavioural EEPROM model serves images built arithmetically, each with a different seed so that the word sums carry and wrap. It checks every command frame, the pulse count and the phase and gap lengths. A sweep over eight valid images walks `host_id` through all eight values with junk in the upper ID bits, flips `act_neg` both with the flag bit alone and with every other option bit set, and steps the tag byte up to 14. This separates a correct byte-lane choice and bit slice from a swapped or shifted one. Further images cover a tag byte of 15 and above (truncation to 0), sums off by one and by 0x8000 (fallback to the defaults), and phase divisors of 0, 1, 2 and 3 (timing scales and 0 behaves as 1).

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

    typedef enum logic [3:0] {
        S_BOOT,
        S_SETUP,
        S_CMD_HI,
        S_DAT_LO,
        S_DAT_HI,
        S_GAP,
        S_CHECK,
        S_DONE,
        S_HALT
    } eecfg_state_e;

endpackage

// File: rtl/eecfg_phase_timer.sv
module eecfg_phase_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase_end
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    always_comb begin
        last      = (div == '0) ? '0 : div - 1'b1;
        phase_end = run && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run || phase_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eecfg_seq.sv
module eecfg_seq
    import eecfg_pkg::*;
#(
    parameter int WORDS    = 64,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int CMD_W    = 8,
    parameter int CMD_BASE = 8'h80,
    parameter int CNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_end,
    output logic              timer_run,
    output logic [ADDR_W-1:0] addr,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic              sample,
    output logic              last_bit,
    output logic              check,
    output logic              done
);
    localparam int CMD_BITS = CMD_W + 1;
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(WORDS - 1);

    eecfg_state_e      state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CMD_W-1:0]  cmd;
    logic [CMD_BITS-1:0] frame_sh;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_BOOT:   if (phase_end) state_nx = S_SETUP;
            S_SETUP:  if (phase_end) state_nx = S_CMD_HI;
            S_CMD_HI: if (phase_end) state_nx = (bit_cnt == CMD_LAST) ? S_DAT_LO : S_SETUP;
            S_DAT_LO: if (phase_end) state_nx = S_DAT_HI;
            S_DAT_HI: if (phase_end) state_nx = (bit_cnt == DAT_LAST) ? S_GAP : S_DAT_LO;
            S_GAP:    if (phase_end) state_nx = (addr == ADDR_LAST) ? S_CHECK : S_SETUP;
            S_CHECK:  state_nx = S_DONE;
            S_DONE:   state_nx = S_HALT;
            S_HALT:   state_nx = S_HALT;
            default:  state_nx = S_HALT;
        endcase
    end

    // state register and bit / word counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_BOOT;
            bit_cnt <= '0;
            addr    <= '0;
        end else begin
            state <= state_nx;
            if (phase_end && state == S_CMD_HI) begin
                bit_cnt <= (bit_cnt == CMD_LAST) ? '0 : bit_cnt + 1'b1;
            end else if (phase_end && state == S_DAT_HI) begin
                bit_cnt <= (bit_cnt == DAT_LAST) ? '0 : bit_cnt + 1'b1;
            end
            if (phase_end && state == S_GAP && addr != ADDR_LAST) begin
                addr <= addr + 1'b1;
            end
        end
    end

    // outputs decoded from the state register
    always_comb begin
        cmd       = CMD_W'(CMD_BASE) | CMD_W'(addr);
        frame_sh  = {1'b1, cmd} << bit_cnt;
        timer_run = 1'b0;
        ee_cs     = 1'b0;
        ee_sk     = 1'b0;
        ee_di     = 1'b0;
        sample    = 1'b0;
        check     = 1'b0;
        done      = 1'b0;
        last_bit  = (bit_cnt == DAT_LAST);
        unique case (state)
            S_BOOT, S_GAP: begin
                timer_run = 1'b1;
            end
            S_SETUP: begin
                timer_run = 1'b1;
                ee_cs     = 1'b1;
                ee_di     = frame_sh[CMD_BITS-1];
            end
            S_CMD_HI: begin
                timer_run = 1'b1;
                ee_cs     = 1'b1;
                ee_sk     = 1'b1;
                ee_di     = frame_sh[CMD_BITS-1];
            end
            S_DAT_LO: begin
                timer_run = 1'b1;
                ee_cs     = 1'b1;
            end
            S_DAT_HI: begin
                timer_run = 1'b1;
                ee_cs     = 1'b1;
                ee_sk     = 1'b1;
                sample    = phase_end;
            end
            S_CHECK: check = 1'b1;
            S_DONE:  done  = 1'b1;
            S_HALT:  ;
            default: ;
        endcase
    end
endmodule

// File: rtl/eecfg_datapath.sv
module eecfg_datapath #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int SIGNATURE = 16'h1234,
    parameter int ID_W      = 3,
    parameter int DEF_ID    = 7,
    parameter int TAG_W     = 16,
    parameter int DEF_TAG   = 16,
    parameter int ID_BYTE   = 8'h40,
    parameter int OPT_BYTE  = 8'h41,
    parameter int TAG_BYTE  = 8'h43,
    parameter int NEG_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ee_do,
    input  logic              sample,
    input  logic              last_bit,
    input  logic              check,
    output logic              valid,
    output logic [ID_W-1:0]   host_id,
    output logic [TAG_W-1:0]  tag_depth,
    output logic              act_neg
);
    localparam logic [ADDR_W-1:0] ID_WORD  = ADDR_W'(ID_BYTE / 2);
    localparam logic [ADDR_W-1:0] OPT_WORD = ADDR_W'(OPT_BYTE / 2);
    localparam logic [ADDR_W-1:0] TAG_WORD = ADDR_W'(TAG_BYTE / 2);
    localparam int ID_LSB  = (ID_BYTE % 2) * 8;
    localparam int OPT_LSB = (OPT_BYTE % 2) * 8;
    localparam int TAG_LSB = (TAG_BYTE % 2) * 8;
    localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(2);

    logic [DATA_W-2:0] shreg;
    logic [DATA_W-1:0] word_new;
    logic [DATA_W-1:0] sum;
    logic [ID_W-1:0]   id_cap;
    logic              neg_cap;
    logic [7:0]        tag_cap;
    logic              word_end;

    assign word_new = {shreg, ee_do};
    assign word_end = sample && last_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            sum     <= '0;
            id_cap  <= '0;
            neg_cap <= 1'b0;
            tag_cap <= '0;
        end else if (sample) begin
            shreg <= word_new[DATA_W-2:0];
            if (word_end) begin
                sum <= sum + word_new;
                if (addr == ID_WORD)  id_cap  <= word_new[ID_LSB +: ID_W];
                if (addr == OPT_WORD) neg_cap <= word_new[OPT_LSB + NEG_BIT];
                if (addr == TAG_WORD) tag_cap <= word_new[TAG_LSB +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid     <= 1'b0;
            host_id   <= ID_W'(DEF_ID);
            tag_depth <= TAG_W'(DEF_TAG);
            act_neg   <= 1'b0;
        end else if (check) begin
            valid <= (sum == DATA_W'(SIGNATURE));
            if (sum == DATA_W'(SIGNATURE)) begin
                host_id   <= id_cap;
                act_neg   <= neg_cap;
                tag_depth <= (tag_cap < 8'(TAG_W - 1)) ? (TAG_ONE << tag_cap) : '0;
            end
        end
    end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
    parameter int WORDS     = 64,
    parameter int DATA_W    = 16,
    parameter int CMD_W     = 8,
    parameter int CMD_BASE  = 8'h80,
    parameter int SIGNATURE = 16'h1234,
    parameter int DIV_W     = 16,
    parameter int ID_W      = 3,
    parameter int DEF_ID    = 7,
    parameter int TAG_W     = 16,
    parameter int DEF_TAG   = 16,
    parameter int ID_BYTE   = 8'h40,
    parameter int OPT_BYTE  = 8'h41,
    parameter int TAG_BYTE  = 8'h43,
    parameter int NEG_BIT   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     phase_div,
    input  logic                 ee_do,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_di,
    output logic                 done,
    output logic                 valid,
    output logic [ID_W-1:0]      host_id,
    output logic [(1<<ID_W)-1:0] id_mask,
    output logic [TAG_W-1:0]     tag_depth,
    output logic                 act_neg
);
    localparam int ADDR_W = $clog2(WORDS);
    localparam int CNT_W  = $clog2(DATA_W + CMD_W + 1);

    logic              timer_run;
    logic              phase_end;
    logic [ADDR_W-1:0] addr;
    logic              sample;
    logic              last_bit;
    logic              check;

    eecfg_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (timer_run),
        .div       (phase_div),
        .phase_end (phase_end)
    );

    eecfg_seq #(
        .WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CMD_W(CMD_W), .CMD_BASE(CMD_BASE), .CNT_W(CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_end (phase_end),
        .timer_run (timer_run),
        .addr      (addr),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di),
        .sample    (sample),
        .last_bit  (last_bit),
        .check     (check),
        .done      (done)
    );

    eecfg_datapath #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIGNATURE(SIGNATURE),
        .ID_W(ID_W), .DEF_ID(DEF_ID), .TAG_W(TAG_W), .DEF_TAG(DEF_TAG),
        .ID_BYTE(ID_BYTE), .OPT_BYTE(OPT_BYTE), .TAG_BYTE(TAG_BYTE),
        .NEG_BIT(NEG_BIT)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .ee_do     (ee_do),
        .sample    (sample),
        .last_bit  (last_bit),
        .check     (check),
        .valid     (valid),
        .host_id   (host_id),
        .tag_depth (tag_depth),
        .act_neg   (act_neg)
    );

    assign id_mask = (1 << ID_W)'(1) << host_id;
endmodule

// File: rtl/eecfg_checker.sv
module eecfg_checker #(
    parameter int ID_W    = 3,
    parameter int DEF_ID  = 7,
    parameter int TAG_W   = 16,
    parameter int DEF_TAG = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ee_cs,
    input logic                 ee_sk,
    input logic                 ee_di,
    input logic                 done,
    input logic                 valid,
    input logic [ID_W-1:0]      host_id,
    input logic [(1<<ID_W)-1:0] id_mask,
    input logic [TAG_W-1:0]     tag_depth,
    input logic                 act_neg
);
    logic finished;

    always_ff @(posedge clk) begin
        if (!rst_n)    finished <= 1'b0;
        else if (done) finished <= 1'b1;
    end

    a_r4_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    a_r1_di_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (!ee_cs && !ee_sk && !done && $stable(valid) && $stable(host_id)));

    a_r10_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(id_mask) && id_mask[host_id]);

    a_r9_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !valid) |-> (host_id == ID_W'(DEF_ID) && !act_neg && tag_depth == TAG_W'(DEF_TAG)));

    a_r9_busy_default: assert property (@(posedge clk) disable iff (!rst_n)
        (!finished && !done) |-> (!valid && host_id == ID_W'(DEF_ID)));
endmodule

bind eeprom_cfg_loader eecfg_checker #(
    .ID_W(ID_W), .DEF_ID(DEF_ID), .TAG_W(TAG_W), .DEF_TAG(DEF_TAG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .done(done), .valid(valid), .host_id(host_id), .id_mask(id_mask),
    .tag_depth(tag_depth), .act_neg(act_neg)
);

// File: tb/eeprom_cfg_loader_tb.sv
module eeprom_cfg_loader_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] phase_div = 16'd1;
    logic        ee_do = 1'b0;
    logic        ee_cs, ee_sk, ee_di, done, valid, act_neg;
    logic [2:0]  host_id;
    logic [7:0]  id_mask;
    logic [15:0] tag_depth;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_cfg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .phase_div(phase_div), .ee_do(ee_do),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .done(done),
        .valid(valid), .host_id(host_id), .id_mask(id_mask),
        .tag_depth(tag_depth), .act_neg(act_neg)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // EEPROM model
    logic [15:0] mem [64];
    int   sk_n, exp_addr, cur, words, err_cmd, err_cnt, err_outside;
    logic [8:0] cmd_sh;

    always @(posedge ee_sk) begin
        if (!ee_cs) err_outside++;
        sk_n++;
        if (sk_n <= 9) cmd_sh = {cmd_sh[7:0], ee_di};
        if (sk_n == 9) begin
            if (cmd_sh != {1'b1, 8'h80 | 8'(exp_addr)}) err_cmd++;
            cur = int'(cmd_sh[5:0]);
            exp_addr++;
        end
        if (sk_n >= 10 && sk_n <= 25) ee_do <= mem[cur][25 - sk_n];
    end
    always @(posedge ee_cs) begin sk_n = 0; words++; end
    always @(negedge ee_cs) if (sk_n != 25) err_cnt++;

    // pin timing monitor
    int   eff, hi_len, lo_len, gap_len, err_ph, min_gap;
    logic p_sk, p_cs;
    always @(negedge clk) if (rst_n) begin
        if (ee_sk) hi_len++;
        if (p_sk && !ee_sk) begin if (hi_len != eff) err_ph++; hi_len = 0; end
        if (ee_cs && !ee_sk) lo_len++;
        if (!p_sk && ee_sk) begin if (lo_len != eff) err_ph++; lo_len = 0; end
        if (!ee_cs) begin gap_len++; lo_len = 0; end
        if (!p_cs && ee_cs) begin if (gap_len < min_gap) min_gap = gap_len; gap_len = 0; end
        p_sk = ee_sk;
        p_cs = ee_cs;
    end

    task automatic run(input int div, input int seed, input logic [7:0] idb,
                       input logic [7:0] optb, input logic [7:0] tagb, input int bad);
        logic [15:0] s;
        logic        e_valid;
        logic [2:0]  e_id;
        logic        e_neg;
        logic [15:0] e_tag;
        int          n;
        logic        v0;
        logic [2:0]  id0;
        int          extra_done, busy_pins, changed;
        s = 16'h0;
        for (int i = 0; i < 63; i++) begin
            mem[i] = 16'(i * 40503 + seed * 977 + 16'h5a5a);
            if (i == 32) mem[i] = {optb, idb};
            if (i == 33) mem[i] = {tagb, 8'(seed)};
            s = s + mem[i];
        end
        mem[63] = 16'h1234 - s + 16'(bad);
        s = s + mem[63];
        e_valid = (s == 16'h1234);
        e_id  = e_valid ? idb[2:0] : 3'd7;
        e_neg = e_valid ? optb[3] : 1'b0;
        e_tag = !e_valid ? 16'd16 : (tagb < 8'd15) ? (16'd2 << tagb) : 16'd0;

        phase_div = 16'(div);
        eff = (div == 0) ? 1 : div;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        sk_n = 0; exp_addr = 0; words = 0; err_cmd = 0; err_cnt = 0; err_outside = 0;
        hi_len = 0; lo_len = 0; gap_len = 0; err_ph = 0; min_gap = 1000000;
        p_sk = 1'b0; p_cs = 1'b0;
        chk(!valid && host_id == 3'd7 && tag_depth == 16'd16 && !act_neg,
            "R9", "reset defaults", {valid, host_id, tag_depth}, {1'b0, 3'd7, 16'd16});
        chk(id_mask == 8'h80, "R10", "reset mask", id_mask, 8'h80);
        chk(!ee_cs && !done, "R11", "reset pins", {ee_cs, done}, 0);
        rst_n = 1'b1;
        n = 0;
        while (!done && n < 40000) begin
            @(negedge clk);
            n++;
            if (n == 200)
                chk(!valid && host_id == 3'd7, "R9", "busy defaults", {valid, host_id}, {1'b0, 3'd7});
        end
        chk(done == 1'b1, "R11", "watchdog: done seen", done, 1);
        chk(err_cmd == 0 && exp_addr == 64, "R1", "command frames", err_cmd, 0);
        chk(err_cnt == 0, "R2", "25 pulses per frame", err_cnt, 0);
        chk(words == 64, "R3", "word count", words, 64);
        chk(err_outside == 0 && min_gap >= eff, "R4", "gap / sk outside cs", min_gap, eff);
        chk(err_ph == 0, "R5", "phase length errors", err_ph, 0);
        chk(valid == e_valid, "R6", "valid", valid, e_valid);
        chk(host_id == e_id, "R7", "host id", host_id, e_id);
        chk(act_neg == e_neg, "R7", "active negation", act_neg, e_neg);
        chk(tag_depth == e_tag, "R8", "tag depth", tag_depth, e_tag);
        chk(id_mask == (8'd1 << e_id), "R10", "id mask", id_mask, 8'd1 << e_id);
        v0 = valid; id0 = host_id;
        extra_done = 0; busy_pins = 0; changed = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (done) extra_done++;
            if (ee_cs || ee_sk) busy_pins++;
            if (valid != v0 || host_id != id0) changed++;
        end
        chk(extra_done == 0 && busy_pins == 0 && changed == 0, "R11", "quiet after done",
            {extra_done, busy_pins, changed}, 0);
    endtask

    initial begin
        // sweep of valid images: every host id, negation flag both ways, tag 0..14
        for (int k = 0; k < 8; k++) begin
            run((k < 6) ? 1 : (k == 6) ? 0 : 3, k + 1,
                {5'(k * 5 + 3), 3'(k)},
                k[0] ? 8'h08 : 8'hF7,
                8'(k * 2), 0);
        end
        run(2, 11, 8'h04, 8'h2C, 8'd15, 0);   // R8 truncation at 15
        run(1, 12, 8'h01, 8'hFF, 8'd200, 0);  // R8 large byte
        run(2, 13, 8'h02, 8'h08, 8'd3, 1);    // R6/R9 sum off by one
        run(1, 14, 8'h05, 8'h08, 8'd4, 16'h8000); // R6/R9 top bit wrong
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule